// File: doc/BRIEF.md
# Linked-Load Reservation Table

This block sits beside a memory-side cache controller and decides whether store-conditional writes may go ahead. It holds up to 32 reservations. Each reservation pairs a physical address with an authentication key. A linked load either finds the reservation already held for its address and returns that key, or takes a fresh key from a wrapping counter and records a new reservation. A store conditional succeeds only when both its address and its key match a live reservation. A success consumes that reservation and lets the data path write. A plain write, which may be a burst described by a low and a high address, cancels every reservation inside that range and is always allowed.

When a new reservation arrives and the table is full, a victim slot is drawn from a free-running LFSR. The draw is deliberately skewed: slot 0 is taken about half the time, and the highest slots almost never. Keys have a bounded life. Whenever a key is handed out, any live reservation whose key lies exactly half the key space away is cancelled, so a key value is never trusted after the counter has moved that far past it.

The block accepts one command per cycle and answers each accepted command exactly one cycle later.

Top module: `llsc_resv_table`

## Requirements
- R1: A synchronous active-low reset clears every reservation and sets the key counter to 0. The first linked load after reset therefore returns key 0, and a store conditional issued before any linked load fails.
- R2: A linked load (cmdOp = 0) whose address matches a live reservation returns that reservation's key and allocates nothing. The next fresh key is unchanged by it.
- R3: A linked load that misses returns the current key counter value, advances the counter by one, and records the address with that key.
- R4: While at least one entry is free, a missing linked load fills a free entry (the lowest-indexed one) and never displaces a live reservation.
- R5: A store conditional (cmdOp = 1) whose address and key both match a live reservation responds with rspCondFail = 0 and rspWriteOk = 1, and removes that reservation. Repeating the same store conditional then fails.
- R6: A store conditional that matches no live reservation on both address and key responds with rspCondFail = 1 and rspWriteOk = 0, and leaves every reservation in place.
- R7: A write (cmdOp = 2) removes every live reservation whose address A satisfies cmdAddr <= A <= cmdAddrHi, with both bounds inclusive. It keeps reservations outside that range and always responds with rspWriteOk = 1.
- R8: A missing linked load on a full table evicts exactly one existing reservation and installs the new one.
- R9: Eviction slots follow a geometric pattern taken from the low 12 LFSR bits: slot i (i < 12) is chosen when bit i is the lowest set bit. Slot 0 is chosen about half the time, and slots 12 and above only when all 12 low bits are zero.
- R10: When a key K' is allocated, every live reservation whose key differs from K' by exactly 2^(KEY_W-1) is removed.
- R11: cmdReady is always high. Every accepted command with opcode 0 to 2 produces rspValid exactly one cycle later. Opcode 3 produces no response and changes nothing. For store conditionals and writes, rspKey is 0. For linked loads and writes, rspCondFail is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command accepted (always high) |
| cmdOp | input | 2 | 0 linked load, 1 store conditional, 2 write, 3 reserved |
| cmdAddr | input | ADDR_W | Address, or low bound of a write range |
| cmdAddrHi | input | ADDR_W | High bound of a write range (inclusive) |
| cmdKey | input | KEY_W | Key presented by a store conditional |
| rspValid | output | 1 | Response present, one cycle after the command |
| rspKey | output | KEY_W | Key returned for a linked load |
| rspCondFail | output | 1 | Store conditional result: 0 success, 1 failure |
| rspWriteOk | output | 1 | Data path may perform the write |

## Verification
Linked loads are tried on repeated, fresh and just-released addresses, which separates a hit returning a stored key from a miss advancing the counter. Store conditionals with a wrong key, a wrong address and the right pair, followed by a repeat, separate consumption from a table left untouched. Writes whose ranges sit exactly on reservations, one address inside and one outside, expose off-by-one bound errors. Repeated fill-then-overflow trials show a single eviction and its skewed slot spread, and a second instance with 8-bit keys reaches the key-aging boundary within a short run.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;

  typedef enum logic [1:0] {
    OP_LINK  = 2'd0,
    OP_COND  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  // Strobes from control to the entry store
  typedef struct packed {
    logic alloc;      // install allocKey/cmdAddr into allocSlot, age old keys
    logic condClear;  // drop the entry at condSlot
    logic rangeClear; // drop entries inside [cmdAddr, cmdAddrHi]
  } strobe_t;

endpackage

// File: rtl/llsc_resv_store.sv
module llsc_resv_store
  import llsc_resv_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 40,
  parameter int KEY_W     = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [SLOT_W-1:0]    allocSlot,
  input  logic [KEY_W-1:0]     allocKey,
  input  logic [SLOT_W-1:0]    condSlot,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [ADDR_W-1:0]    cmdAddrHi,
  input  logic [KEY_W-1:0]     cmdKey,
  output logic [NUM_SLOTS-1:0] validVec,
  output logic [NUM_SLOTS-1:0] addrMatch,
  output logic [NUM_SLOTS-1:0] condMatch,
  output logic [KEY_W-1:0]     hitKey
);

  localparam logic [KEY_W-1:0] AGE_FLIP = {1'b1, {(KEY_W-1){1'b0}}};

  logic [NUM_SLOTS-1:0] validQ;
  logic [ADDR_W-1:0]    addrQ [NUM_SLOTS];
  logic [KEY_W-1:0]     keyQ  [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] rangeMatch;
  logic [NUM_SLOTS-1:0] ageMatch;
  logic [NUM_SLOTS-1:0] clearVec;
  logic [KEY_W-1:0]     staleKey;

  assign validVec = validQ;
  assign staleKey = allocKey ^ AGE_FLIP;

  always_comb begin
    hitKey = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      addrMatch[i]  = validQ[i] && (addrQ[i] == cmdAddr);
      condMatch[i]  = addrMatch[i] && (keyQ[i] == cmdKey);
      rangeMatch[i] = validQ[i] && (addrQ[i] >= cmdAddr) && (addrQ[i] <= cmdAddrHi);
      ageMatch[i]   = validQ[i] && (keyQ[i] == staleKey);
      clearVec[i]   = (strobe.alloc && ageMatch[i])
                   || (strobe.condClear && (condSlot == SLOT_W'(i)))
                   || (strobe.rangeClear && rangeMatch[i]);
      if (addrMatch[i]) hitKey = hitKey | keyQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strobe.alloc && (allocSlot == SLOT_W'(i))) validQ[i] <= 1'b1;
        else if (clearVec[i])                          validQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (strobe.alloc && (allocSlot == SLOT_W'(i))) begin
        addrQ[i] <= cmdAddr;
        keyQ[i]  <= allocKey;
      end
    end
  end

  // R3: an allocated slot is live on the next cycle
  assert_alloc_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> validQ[$past(allocSlot)]);

  // R5: a successful store conditional consumes its entry
  assert_cond_consumes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.condClear && !strobe.alloc) |=> !validQ[$past(condSlot)]);

  // R7: nothing in the written range survives
  assert_range_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rangeClear |=> ((validQ & $past(rangeMatch)) == '0));

  // R2: an address is reserved at most once
  assert_unique_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(addrMatch));

endmodule

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl
  import llsc_resv_pkg::*;
#(
  parameter int              NUM_SLOTS = 32,
  parameter int              KEY_W     = 32,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int              PICK_W    = 12,
  parameter int              SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  output logic                 cmdReady,
  input  logic [NUM_SLOTS-1:0] validVec,
  input  logic [NUM_SLOTS-1:0] addrMatch,
  input  logic [NUM_SLOTS-1:0] condMatch,
  input  logic [KEY_W-1:0]     hitKey,
  output strobe_t              strobe,
  output logic [SLOT_W-1:0]    allocSlot,
  output logic [KEY_W-1:0]     allocKey,
  output logic [SLOT_W-1:0]    condSlot,
  output logic                 rspValid,
  output logic [KEY_W-1:0]     rspKey,
  output logic                 rspCondFail,
  output logic                 rspWriteOk
);

  localparam int TAIL = NUM_SLOTS - PICK_W;

  op_e               op;
  logic              accept;
  logic              isLink, isCond, isWrite;
  logic              linkHit, condHit, tableFull;
  logic [SLOT_W-1:0] freeSlot, victimSlot;
  logic [KEY_W-1:0]  keyCntQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [PICK_W-1:0] pickBits;

  assign cmdReady = 1'b1;
  assign op       = op_e'(cmdOp);
  assign accept   = cmdValid && (op != OP_RSVD);
  assign isLink   = accept && (op == OP_LINK);
  assign isCond   = accept && (op == OP_COND);
  assign isWrite  = accept && (op == OP_WRITE);

  assign linkHit   = |addrMatch;
  assign condHit   = |condMatch;
  assign tableFull = &validVec;
  assign pickBits  = lfsrQ[PICK_W-1:0];

  // lowest free entry
  always_comb begin
    freeSlot = '0;
    for (int i = NUM_SLOTS-1; i >= 0; i--) begin
      if (!validVec[i]) freeSlot = SLOT_W'(i);
    end
  end

  // geometric victim: lowest set random bit, tail slots when all clear
  always_comb begin
    victimSlot = SLOT_W'(PICK_W + (int'(lfsrQ[LFSR_W-1:PICK_W]) % TAIL));
    for (int i = PICK_W-1; i >= 0; i--) begin
      if (pickBits[i]) victimSlot = SLOT_W'(i);
    end
  end

  always_comb begin
    condSlot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (condMatch[i]) condSlot = SLOT_W'(i);
    end
  end

  assign allocSlot = tableFull ? victimSlot : freeSlot;
  assign allocKey  = keyCntQ;

  always_comb begin
    strobe            = '0;
    strobe.alloc      = isLink && !linkHit;
    strobe.condClear  = isCond && condHit;
    strobe.rangeClear = isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCntQ <= '0;
      lfsrQ   <= LFSR_SEED;
    end else begin
      lfsrQ <= (lfsrQ >> 1) ^ (lfsrQ[0] ? LFSR_TAPS : '0);
      if (strobe.alloc) keyCntQ <= keyCntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspKey      <= '0;
      rspCondFail <= 1'b0;
      rspWriteOk  <= 1'b0;
    end else begin
      rspValid    <= accept;
      rspKey      <= isLink ? (linkHit ? hitKey : keyCntQ) : '0;
      rspCondFail <= isCond && !condHit;
      rspWriteOk  <= isWrite || (isCond && condHit);
    end
  end

  // R3: a fresh key advances the counter by one
  assert_key_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> (keyCntQ == $past(keyCntQ) + 1'b1));

  // R2: a linked-load hit leaves the counter alone
  assert_hit_no_alloc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isLink && linkHit) |=> $stable(keyCntQ));

  // R11: response exactly one cycle after an accepted command
  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

  // R6: a failed store conditional never permits the write
  assert_fail_blocks_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspCondFail |-> !rspWriteOk);

  // R9: the random source never locks up
  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_resv_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 40,
  parameter int KEY_W     = 32,
  parameter int LFSR_W    = 16,
  parameter int PICK_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] cmdAddrHi,
  input  logic [KEY_W-1:0]  cmdKey,
  output logic              rspValid,
  output logic [KEY_W-1:0]  rspKey,
  output logic              rspCondFail,
  output logic              rspWriteOk
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  strobe_t              strobe;
  logic [SLOT_W-1:0]    allocSlot, condSlot;
  logic [KEY_W-1:0]     allocKey, hitKey;
  logic [NUM_SLOTS-1:0] validVec, addrMatch, condMatch;

  llsc_resv_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .LFSR_W(LFSR_W), .PICK_W(PICK_W),
    .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReady(cmdReady), .validVec(validVec), .addrMatch(addrMatch),
    .condMatch(condMatch), .hitKey(hitKey), .strobe(strobe),
    .allocSlot(allocSlot), .allocKey(allocKey), .condSlot(condSlot),
    .rspValid(rspValid), .rspKey(rspKey), .rspCondFail(rspCondFail),
    .rspWriteOk(rspWriteOk)
  );

  llsc_resv_store #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocSlot(allocSlot),
    .allocKey(allocKey), .condSlot(condSlot), .cmdAddr(cmdAddr),
    .cmdAddrHi(cmdAddrHi), .cmdKey(cmdKey), .validVec(validVec),
    .addrMatch(addrMatch), .condMatch(condMatch), .hitKey(hitKey)
  );

endmodule

// File: tb/llsc_resv_table_tb.sv
module llsc_resv_table_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [39:0] cmdAddr = '0;
  logic [39:0] cmdAddrHi = '0;
  logic [31:0] cmdKey = '0;

  logic        cmdReady, rspValid, rspCondFail, rspWriteOk;
  logic [31:0] rspKey;
  logic        aReady, aValid, aFail, aOk;
  logic [7:0]  aKey;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_table u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdAddrHi(cmdAddrHi), .cmdKey(cmdKey),
    .rspValid(rspValid), .rspKey(rspKey), .rspCondFail(rspCondFail),
    .rspWriteOk(rspWriteOk)
  );

  // short-key copy to reach the aging boundary quickly
  llsc_resv_table #(.KEY_W(8)) u_dutAge (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(aReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdAddrHi(cmdAddrHi), .cmdKey(cmdKey[7:0]),
    .rspValid(aValid), .rspKey(aKey), .rspCondFail(aFail), .rspWriteOk(aOk)
  );

  typedef struct {
    string       req;
    logic        chkKey;
    logic [31:0] key;
    logic        fail;
    logic        ok;
    logic        probe;
    int          slot;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int probeFails = 0;
  int probeSlot = -1;
  int mainKey = 0;
  bit done = 1'b0;

  task automatic report(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expectations as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (q.size() == 0) begin
        report("R11", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.probe) begin
          if (rspCondFail) begin
            probeFails++;
            probeSlot = e.slot;
          end
        end else begin
          if (e.chkKey) report(e.req, "rspKey", rspKey, e.key);
          report(e.req, "rspCondFail", rspCondFail, e.fail);
          report(e.req, "rspWriteOk", rspWriteOk, e.ok);
        end
      end
    end
  end

  task automatic drive(logic [1:0] op, logic [39:0] lo, logic [39:0] hi, logic [31:0] key);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = lo; cmdAddrHi = hi; cmdKey = key;
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic ll(logic [39:0] a, int expKey, string req);
    exp_t e;
    e = '{req: req, chkKey: 1'b1, key: 32'(expKey), fail: 1'b0, ok: 1'b0, probe: 1'b0, slot: 0};
    drive(2'd0, a, a, 32'd0);
    q.push_back(e);
  endtask

  task automatic sc(logic [39:0] a, int key, logic expFail, string req);
    exp_t e;
    e = '{req: req, chkKey: 1'b1, key: 32'd0, fail: expFail, ok: !expFail, probe: 1'b0, slot: 0};
    drive(2'd1, a, a, 32'(key));
    q.push_back(e);
  endtask

  task automatic probe(logic [39:0] a, int key, int slot);
    exp_t e;
    e = '{req: "R8", chkKey: 1'b0, key: 32'd0, fail: 1'b0, ok: 1'b0, probe: 1'b1, slot: slot};
    drive(2'd1, a, a, 32'(key));
    q.push_back(e);
  endtask

  task automatic wr(logic [39:0] lo, logic [39:0] hi, string req);
    exp_t e;
    e = '{req: req, chkKey: 1'b1, key: 32'd0, fail: 1'b0, ok: 1'b1, probe: 1'b0, slot: 0};
    drive(2'd2, lo, hi, 32'd0);
    q.push_back(e);
  endtask

  // fresh-key linked load on the main instance
  task automatic llNew(logic [39:0] a, string req);
    ll(a, mainKey, req);
    mainKey++;
  endtask

  task automatic resetDut();
    @(negedge clk);
    cmdValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mainKey = 0;
  endtask

  task automatic settle();
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int keys [NSLOT+1];
    int hist [NSLOT];
    int tailCnt;
    foreach (hist[i]) hist[i] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R11: idle state after reset
    report("R1", "rspValid after reset", rspValid, 0);
    report("R11", "cmdReady", cmdReady, 1);

    // ---- key aging (R10), observed on the 8-bit-key copy ----
    llNew(40'h100, "R3");
    for (int j = 1; j < 128; j++) begin
      llNew(40'h2000 + 40'(j), "R3");
      sc(40'h2000 + 40'(j), j, 1'b0, "R5");
    end
    ll(40'h100, 0, "R2");
    idle();
    report("R10", "short-key hit before boundary", aKey, 0);
    llNew(40'h200, "R3");
    idle();
    report("R10", "short-key allocation 128", aKey, 128);
    ll(40'h100, 0, "R2");
    idle();
    report("R10", "aged entry re-allocated", aKey, 129);
    @(negedge clk);

    // ---- reset clears state (R1) ----
    resetDut();
    sc(40'h100, 0, 1'b1, "R1");
    llNew(40'h300, "R1");
    // R2 hit then R3 consecutive key
    ll(40'h300, 0, "R2");
    llNew(40'h301, "R3");
    // R6 misses
    sc(40'h300, 5, 1'b1, "R6");
    sc(40'h999, 0, 1'b1, "R6");
    // R5 success then repeat fails
    sc(40'h300, 0, 1'b0, "R5");
    sc(40'h300, 0, 1'b1, "R5");

    // ---- write range (R7) ----
    llNew(40'h40F, "R7");   // key 2
    llNew(40'h410, "R7");   // key 3
    llNew(40'h418, "R7");   // key 4
    llNew(40'h420, "R7");   // key 5
    llNew(40'h421, "R7");   // key 6
    wr(40'h410, 40'h420, "R7");
    ll(40'h40F, 2, "R7");
    ll(40'h421, 6, "R7");
    llNew(40'h410, "R7");
    llNew(40'h418, "R7");
    llNew(40'h420, "R7");
    wr(40'h5000, 40'h5FFF, "R7");
    ll(40'h301, 1, "R7");
    wr(40'h0, 40'hFF_FFFF_FFFF, "R7");
    llNew(40'h301, "R7");
    wr(40'h0, 40'hFF_FFFF_FFFF, "R7");

    // ---- reserved opcode (R11) ----
    drive(2'd3, 40'h301, 40'h301, 32'd0);
    idle();
    report("R11", "no response to reserved op", rspValid, 0);

    // ---- free entries are used before eviction (R4) ----
    for (int i = 0; i < NSLOT; i++) begin
      keys[i] = mainKey;
      llNew(40'h1000 + 40'(i), "R4");
    end
    for (int i = 0; i < NSLOT; i++) sc(40'h1000 + 40'(i), keys[i], 1'b0, "R4");

    // ---- eviction trials (R8, R9) ----
    for (int t = 0; t < 64; t++) begin
      for (int i = 0; i <= NSLOT; i++) begin
        keys[i] = mainKey;
        llNew(40'h1000 + 40'(i), "R8");
      end
      settle();
      probeFails = 0;
      probeSlot = -1;
      for (int i = 0; i < NSLOT; i++) probe(40'h1000 + 40'(i), keys[i], i);
      sc(40'h1000 + 40'(NSLOT), keys[NSLOT], 1'b0, "R8");
      settle();
      report("R8", "evictions per overflow", probeFails, 1);
      if (probeSlot >= 0) hist[probeSlot]++;
    end
    tailCnt = 0;
    for (int i = 12; i < NSLOT; i++) tailCnt += hist[i];
    report("R9", "slot0 share in range", (hist[0] >= 12 && hist[0] <= 52), 1);
    report("R9", "tail slots rare", (tailCnt <= 3), 1);
    report("R9", "slot0 more frequent than slot3", (hist[0] > hist[3]), 1);

    settle();
    report("R11", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule